// File: doc/BRIEF.md
# Burst Column Sequencer with Read Latency Timing

This block sits between the command decoder of a synchronous two-bank graphics DRAM and its column path. A mode-set strobe carries a 10-bit key. From that key the block stores three settings: how many beats a burst has, whether the beats go in sequential or interleaved order, and how many cycles pass between a read column access and its data on the pins. Each read or write strobe starts a new burst at a given column. The block then presents one column address per cycle for as many cycles as the burst needs.

Writes have zero latency. The first beat's column, together with a per-byte write enable, appears in the same cycle as the write strobe. Reads come out of a short pipeline that delays a per-byte output enable by the programmed latency. A separate fixed two-cycle delay applies the byte mask to that enable. A precharge strobe ends a burst and removes queued read data, and how much data survives depends on the latency. Any new column command cuts off the burst in progress.

Top module: `burst_col_ctrl`

## Requirements
- R1: Key bits [2:0] set the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8. A burst of length N drives col_valid for exactly N cycles, starting in the cycle of the command. A new setting takes effect from the cycle after the mode-set strobe.
- R2: A key is reserved if any of the following holds: bits [2:0] are 100, 101 or 110; bits [2:0] are 111 with bit 3 high; bits [6:4] are not 001, 010 or 011; bits [9:7] are not all zero. A reserved key sets mode_bad and keeps the previous settings. A valid key clears mode_bad. mode_bad changes only on a mode-set strobe.
- R3: When key bit 3 is 0 (sequential), beat i addresses the column (start mod L + i) mod L within the L-aligned block that holds the start column, where L is the burst length.
- R4: When key bit 3 is 1 (interleaved), beat i addresses the start column with its low log2(L) bits XORed with i.
- R5: Key bits [2:0] = 111 with bit 3 = 0 select a full-page burst. Beat i addresses (start + i) mod 256. The burst does not end by itself and wraps past column 255.
- R6: A write strobe puts the start column and col_write on the outputs in the same cycle. On every write beat, wr_byte_en equals the inverse of byte_mask in that cycle. When no write beat is issued, wr_byte_en is 0.
- R7: Key bits [6:4] set the read latency CL (001 gives 1, 010 gives 2, 011 gives 3). A read beat issued in cycle k raises rd_valid in cycle k+CL. rd_byte_oe is never nonzero while rd_valid is low.
- R8: In a cycle where rd_valid is high, rd_byte_oe equals the inverse of the byte_mask applied two cycles earlier, whatever the latency.
- R9: A precharge strobe in cycle P ends the burst, so no column is issued in cycle P. Read data is suppressed from cycle P+1 onward when CL is 1, and from cycle P+2 onward when CL is 2 or 3.
- R10: A read or write strobe during a burst ends that burst. The new burst's first column appears in the same cycle.
- R11: After reset, the settings are burst length 1, sequential order and CL 3. All outputs are low.
- R12: A precharge strobe takes priority over a simultaneous column strobe, and a write strobe takes priority over a simultaneous read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_set | input | 1 | Strobe that loads the mode key |
| mode_key | input | 10 | Mode key |
| rd_cmd | input | 1 | Read column strobe |
| wr_cmd | input | 1 | Write column strobe |
| pre_cmd | input | 1 | Precharge strobe; ends the burst |
| cmd_col | input | COL_W | Start column of a read or write |
| byte_mask | input | BYTES | Per-byte mask, high masks the byte |
| col_addr | output | COL_W | Column address of this cycle |
| col_valid | output | 1 | A column access is issued this cycle |
| col_write | output | 1 | The issued access is a write |
| wr_byte_en | output | BYTES | Per-byte write enable |
| rd_valid | output | 1 | Read data slot on the pins this cycle |
| rd_byte_oe | output | BYTES | Per-byte output enable for read data |
| mode_bad | output | 1 | Last mode key was reserved |

## Verification
The bench uses the defaults: an 8-bit column, four byte lanes and a maximum latency of 3. With these values the 256-column full page is short enough to run past its wrap point. Every combination of latency, order and fixed burst length is swept from four start columns, including columns that sit near a block boundary and near the end of the page. Each read is followed until its last delayed enable. Precharge cut-offs are applied at every latency to show the one-cycle versus two-cycle difference. The byte mask cycles through varying patterns during both reads and writes, which exposes the fixed two-cycle mask delay.

// File: rtl/bcl_pkg.sv
// Package for the burst column sequencer: the stored mode fields and
// the decoder that checks a mode key and flags reserved keys.
package bcl_pkg;

    localparam int unsigned KEY_W = 10;

    typedef struct packed {
        logic       full;    // full-page burst
        logic [1:0] bl_log;  // log2 of burst length when not full page
        logic       ilv;     // interleaved order
        logic [1:0] cl;      // read latency 1..3
    } bcl_mode_t;

    typedef struct packed {
        logic      ok;
        bcl_mode_t m;
    } bcl_decode_t;

    // Turn a key into mode fields; ok is low for any reserved encoding.
    function automatic bcl_decode_t bcl_decode(input logic [KEY_W-1:0] key);
        bcl_decode_t d;
        d.ok       = 1'b1;
        d.m.full   = 1'b0;
        d.m.bl_log = key[1:0];
        d.m.ilv    = key[3];
        d.m.cl     = key[5:4];
        case (key[2:0])
            3'b000, 3'b001, 3'b010, 3'b011: d.ok = 1'b1;
            3'b111: begin
                d.m.full   = 1'b1;
                d.m.bl_log = 2'd0;
                if (key[3]) d.ok = 1'b0;
            end
            default: d.ok = 1'b0;
        endcase
        if (key[6] || key[5:4] == 2'd0) d.ok = 1'b0;
        if (key[9:7] != 3'd0) d.ok = 1'b0;
        return d;
    endfunction

endpackage

// File: rtl/bcl_mode_reg.sv
// Mode register: loads decoded fields on a mode-set strobe.
// Assumes mode_set is a single-cycle strobe. A reserved key leaves the
// stored fields unchanged and raises a flag until the next valid key.
module bcl_mode_reg
    import bcl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_set,
    input  logic [KEY_W-1:0] mode_key,
    output bcl_mode_t        mode,
    output logic             mode_bad
);

    bcl_decode_t dec;

    // Decode the incoming key.
    always_comb dec = bcl_decode(mode_key);

    // Hold fields and reserved flag; reset to BL1, sequential, CL3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode.full   <= 1'b0;
            mode.bl_log <= 2'd0;
            mode.ilv    <= 1'b0;
            mode.cl     <= 2'd3;
            mode_bad    <= 1'b0;
        end else if (mode_set) begin
            if (dec.ok) begin
                mode     <= dec.m;
                mode_bad <= 1'b0;
            end else begin
                mode_bad <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcl_col_seq.sv
// Column sequencer: produces one column per cycle for the running burst.
// Beat 0 is combinational from the command so that writes have zero
// latency. Later beats come from a stored start column and beat counter.
// Assumes go_rd, go_wr and pre are already prioritised and exclusive.
module bcl_col_seq
    import bcl_pkg::*;
#(
    parameter int unsigned COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bcl_mode_t        mode,
    input  logic             go_rd,
    input  logic             go_wr,
    input  logic             pre,
    input  logic [COL_W-1:0] cmd_col,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_write
);

    localparam logic [COL_W-1:0] ONES = {COL_W{1'b1}};

    logic             active_q;
    logic             wr_q;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] span_m;
    logic [COL_W-1:0] cur_start;
    logic [COL_W-1:0] cur_i;
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;
    logic             go;

    assign go = go_rd | go_wr;

    // Mask of the bits that change within one burst block.
    always_comb span_m = mode.full ? ONES : ~(ONES << mode.bl_log);

    // Address of the current beat in either order.
    always_comb begin
        cur_start = go ? cmd_col : start_q;
        cur_i     = go ? '0 : cnt_q;
        seq_low   = (cur_start + cur_i) & span_m;
        ilv_low   = (cur_start ^ cur_i) & span_m;
        col_addr  = (cur_start & ~span_m) | (mode.ilv ? ilv_low : seq_low);
        col_valid = !pre && (go || active_q);
        col_write = col_valid && (go ? go_wr : wr_q);
    end

    // Burst state: start, stop on precharge or last beat, restart on command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            start_q  <= '0;
            cnt_q    <= '0;
        end else if (pre) begin
            active_q <= 1'b0;
        end else if (go) begin
            start_q  <= cmd_col;
            wr_q     <= go_wr;
            cnt_q    <= COL_W'(1);
            active_q <= mode.full || (span_m != '0);
        end else if (active_q) begin
            cnt_q <= cnt_q + COL_W'(1);
            if (!mode.full && cnt_q == span_m) active_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bcl_rd_pipe.sv
// Read timing pipe: delays each read beat by the programmed latency and
// applies the byte mask seen two cycles before the data slot.
// Stage j holds a slot that reaches the pins j cycles after the next edge.
// Precharge keeps only the slot that is due in the next cycle.
module bcl_rd_pipe #(
    parameter int unsigned MAX_CL = 3,
    parameter int unsigned BYTES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cl,
    input  logic             rd_issue,
    input  logic             pre,
    input  logic [BYTES-1:0] byte_mask,
    output logic             rd_valid,
    output logic [BYTES-1:0] rd_byte_oe
);

    localparam int unsigned MASK_DLY = 2;

    logic [MAX_CL-1:0] stage_q;
    logic [MAX_CL-1:0] stage_d;
    logic [BYTES-1:0]  mask_q [MASK_DLY];

    // Shift slots forward, truncate on precharge, insert new read at CL-1.
    always_comb begin
        stage_d = '0;
        for (int j = 0; j + 1 < int'(MAX_CL); j++) begin
            stage_d[j] = stage_q[j+1];
        end
        if (pre) begin
            for (int j = 1; j < int'(MAX_CL); j++) stage_d[j] = 1'b0;
        end
        if (rd_issue && cl != 2'd0 && int'(cl) <= int'(MAX_CL)) begin
            stage_d[int'(cl) - 1] = 1'b1;
        end
    end

    // Latency slot register.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    // Fixed two-deep byte mask delay line.
    generate
        for (genvar g = 0; g < MASK_DLY; g++) begin : g_mask
            always_ff @(posedge clk) begin
                if (!rst_n)      mask_q[g] <= '0;
                else if (g == 0) mask_q[g] <= byte_mask;
                else             mask_q[g] <= mask_q[g-1];
            end
        end
    endgenerate

    assign rd_valid   = stage_q[0];
    assign rd_byte_oe = stage_q[0] ? ~mask_q[MASK_DLY-1] : '0;

endmodule

// File: rtl/burst_col_ctrl.sv
// Top: mode register, column sequencer and read timing pipe.
// Sorts colliding strobes (precharge, then write, then read) and gates
// the write byte enables with the same-cycle byte mask.
module burst_col_ctrl
    import bcl_pkg::*;
#(
    parameter int unsigned COL_W  = 8,
    parameter int unsigned BYTES  = 4,
    parameter int unsigned MAX_CL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_set,
    input  logic [9:0]       mode_key,
    input  logic             rd_cmd,
    input  logic             wr_cmd,
    input  logic             pre_cmd,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [BYTES-1:0] byte_mask,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_write,
    output logic [BYTES-1:0] wr_byte_en,
    output logic             rd_valid,
    output logic [BYTES-1:0] rd_byte_oe,
    output logic             mode_bad
);

    bcl_mode_t mode;
    logic      go_rd;
    logic      go_wr;

    // Strobe priority: precharge over write over read.
    always_comb begin
        go_wr = wr_cmd && !pre_cmd;
        go_rd = rd_cmd && !wr_cmd && !pre_cmd;
    end

    bcl_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_set (mode_set),
        .mode_key (mode_key),
        .mode     (mode),
        .mode_bad (mode_bad)
    );

    bcl_col_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .go_rd     (go_rd),
        .go_wr     (go_wr),
        .pre       (pre_cmd),
        .cmd_col   (cmd_col),
        .col_addr  (col_addr),
        .col_valid (col_valid),
        .col_write (col_write)
    );

    // Write byte enables follow the mask of the same cycle.
    assign wr_byte_en = col_write ? ~byte_mask : '0;

    bcl_rd_pipe #(.MAX_CL(MAX_CL), .BYTES(BYTES)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cl         (mode.cl),
        .rd_issue   (col_valid && !col_write),
        .pre        (pre_cmd),
        .byte_mask  (byte_mask),
        .rd_valid   (rd_valid),
        .rd_byte_oe (rd_byte_oe)
    );

endmodule

// File: rtl/bcl_checker.sv
// Checker for burst_col_ctrl, attached by bind. Relates the strobes at
// the ports to the column and read-enable outputs over time.
module bcl_checker #(
    parameter int unsigned COL_W = 8,
    parameter int unsigned BYTES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_set,
    input logic             rd_cmd,
    input logic             wr_cmd,
    input logic             pre_cmd,
    input logic [COL_W-1:0] cmd_col,
    input logic [BYTES-1:0] byte_mask,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             col_write,
    input logic [BYTES-1:0] wr_byte_en,
    input logic             rd_valid,
    input logic [BYTES-1:0] rd_byte_oe,
    input logic             mode_bad
);

    p_wr_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !pre_cmd) |-> (col_valid && col_write && col_addr == cmd_col
                                  && wr_byte_en == ~byte_mask));

    p_no_wr_en_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !col_write |-> wr_byte_en == '0);

    p_oe_needs_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_byte_oe == '0);

    p_mask_two_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_byte_oe == ~$past(byte_mask, 2));

    p_pre_no_col_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cmd |-> !col_valid);

    p_pre_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cmd ##1 !rd_cmd) |=> !rd_valid);

    p_beat_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !rd_cmd && !wr_cmd) |-> $past(col_valid));

    p_bad_only_on_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_set |=> $stable(mode_bad));

    p_wr_over_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && rd_cmd && !pre_cmd) |-> col_write);

endmodule

bind burst_col_ctrl bcl_checker #(.COL_W(COL_W), .BYTES(BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_set   (mode_set),
    .rd_cmd     (rd_cmd),
    .wr_cmd     (wr_cmd),
    .pre_cmd    (pre_cmd),
    .cmd_col    (cmd_col),
    .byte_mask  (byte_mask),
    .col_addr   (col_addr),
    .col_valid  (col_valid),
    .col_write  (col_write),
    .wr_byte_en (wr_byte_en),
    .rd_valid   (rd_valid),
    .rd_byte_oe (rd_byte_oe),
    .mode_bad   (mode_bad)
);

// File: tb/burst_col_ctrl_bench.sv
// Sweep bench for burst_col_ctrl: drives inputs after the falling edge,
// samples 1 ns later, and computes every expected value arithmetically.
module burst_col_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NONE = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_set = 1'b0;
    logic [9:0] mode_key = '0;
    logic       rd_cmd = 1'b0;
    logic       wr_cmd = 1'b0;
    logic       pre_cmd = 1'b0;
    logic [7:0] cmd_col = '0;
    logic [3:0] byte_mask = '0;
    logic [7:0] col_addr;
    logic       col_valid;
    logic       col_write;
    logic [3:0] wr_byte_en;
    logic       rd_valid;
    logic [3:0] rd_byte_oe;
    logic       mode_bad;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_ctrl u_burst_col_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_key(mode_key),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .pre_cmd(pre_cmd), .cmd_col(cmd_col),
        .byte_mask(byte_mask), .col_addr(col_addr), .col_valid(col_valid),
        .col_write(col_write), .wr_byte_en(wr_byte_en), .rd_valid(rd_valid),
        .rd_byte_oe(rd_byte_oe), .mode_bad(mode_bad)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    function automatic logic [9:0] mkey(input int cl, input int ilv, input int blc);
        return {3'b000, 3'(cl), 1'(ilv), 3'(blc)};
    endfunction

    function automatic logic [3:0] mpat(input bit on, input int c);
        if (!on || c < 0) return 4'h0;
        return 4'((c * 5 + 3) % 16);
    endfunction

    // Expected column of beat i (bl = 0 means full page).
    function automatic int exp_col(input int st, input int bl, input bit ilv, input int i);
        int base;
        if (bl == 0) return (st + i) % 256;
        base = st - (st % bl);
        if (ilv) return base + ((st % bl) ^ i);
        return base + ((st % bl) + i) % bl;
    endfunction

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rd_cmd = 0; wr_cmd = 0; pre_cmd = 0; mode_set = 0; byte_mask = 0;
        end
    endtask

    task automatic set_mode(input logic [9:0] key);
        @(negedge clk);
        mode_set = 1; mode_key = key;
        @(negedge clk);
        mode_set = 0;
    endtask

    // One burst from cycle 0, optional precharge, every cycle checked.
    task automatic run_burst(input bit wr, input int st, input int bl, input bit ilv,
                             input int cl, input int pre_at, input bit mon, input int ncyc);
        string atag;
        atag = (bl == 0) ? "R5" : (ilv ? "R4" : "R3");
        for (int c = 0; c < ncyc; c++) begin
            bit ev;
            bit erv;
            int j;
            int cut;
            logic [3:0] ewe;
            logic [3:0] eoe;
            @(negedge clk);
            rd_cmd = (c == 0) && !wr;
            wr_cmd = (c == 0) && wr;
            pre_cmd = (c == pre_at);
            cmd_col = 8'(st);
            byte_mask = mpat(mon, c);
            #1;
            ev = ((bl == 0) || c < bl) && c < pre_at;
            chk(col_valid == ev, "R1 col_valid", int'(col_valid), int'(ev));
            if (ev) begin
                chk(int'(col_addr) == exp_col(st, bl, ilv, c), atag, int'(col_addr),
                    exp_col(st, bl, ilv, c));
                chk(col_write == wr, "R6 col_write", int'(col_write), int'(wr));
            end
            ewe = (wr && ev) ? ~mpat(mon, c) : 4'h0;
            chk(wr_byte_en == ewe, "R6 wr_byte_en", int'(wr_byte_en), int'(ewe));
            j = c - cl;
            cut = (pre_at == NONE) ? NONE : pre_at + ((cl == 1) ? 1 : 2);
            erv = !wr && j >= 0 && ((bl == 0) || j < bl) && j < pre_at && c < cut;
            eoe = erv ? ~mpat(mon, c - 2) : 4'h0;
            chk(rd_valid == erv, (pre_at == NONE) ? "R7 rd_valid" : "R9 rd_valid",
                int'(rd_valid), int'(erv));
            chk(rd_byte_oe == eoe, mon ? "R8 rd_byte_oe" : "R7 rd_byte_oe",
                int'(rd_byte_oe), int'(eoe));
        end
        idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R11: reset state of all outputs
        chk(col_valid == 0 && rd_valid == 0 && rd_byte_oe == 0 && wr_byte_en == 0,
            "R11 outputs", int'(col_valid), 0);
        chk(mode_bad == 0, "R11 mode_bad", int'(mode_bad), 0);
        // R11: default BL1, sequential, CL3
        run_burst(0, 8'h33, 1, 0, 3, NONE, 0, 6);

        // R1 R3 R4 R6 R7 R8: sweep of latency, order, length and start
        for (int cl = 1; cl <= 3; cl++)
            for (int ilv = 0; ilv < 2; ilv++)
                for (int blc = 0; blc < 4; blc++)
                    for (int s = 0; s < 4; s++) begin
                        int st;
                        st = (s == 0) ? 8'h00 : (s == 1) ? 8'h05 : (s == 2) ? 8'hFE : 8'h9B;
                        set_mode(mkey(cl, ilv, blc));
                        run_burst(0, st, 1 << blc, ilv[0], cl, NONE, s == 1, (1 << blc) + cl + 2);
                        run_burst(1, st, 1 << blc, ilv[0], cl, NONE, s == 2, (1 << blc) + 2);
                    end

        // R9: precharge cut-off at each latency
        for (int cl = 1; cl <= 3; cl++) begin
            set_mode(mkey(cl, 0, 3));
            run_burst(0, 8'h10, 8, 0, cl, 4, 1, 10);
            run_burst(0, 8'h27, 8, 0, cl, 1, 0, 6);
        end

        // R5: full page wraps past 255 and continues until precharge
        set_mode(mkey(2, 0, 7));
        chk(mode_bad == 0, "R5 mode_bad", int'(mode_bad), 0);
        run_burst(0, 8'hF0, 0, 0, 2, 262, 0, 266);
        run_burst(1, 8'hFD, 0, 0, 2, 10, 1, 12);

        // R2: reserved keys flag and keep BL4, sequential, CL2
        set_mode(mkey(2, 0, 2));
        set_mode(mkey(2, 0, 4));
        chk(mode_bad == 1, "R2 bl code 100", int'(mode_bad), 1);
        run_burst(0, 8'h41, 4, 0, 2, NONE, 0, 7);
        set_mode(mkey(1, 1, 7));
        chk(mode_bad == 1, "R2 full interleaved", int'(mode_bad), 1);
        run_burst(0, 8'h41, 4, 0, 2, NONE, 0, 7);
        set_mode(mkey(0, 0, 1));
        chk(mode_bad == 1, "R2 latency 000", int'(mode_bad), 1);
        set_mode(10'h200 | mkey(1, 0, 1));
        chk(mode_bad == 1, "R2 bit 9 high", int'(mode_bad), 1);
        set_mode(10'h080 | mkey(1, 0, 1));
        chk(mode_bad == 1, "R2 bit 7 high", int'(mode_bad), 1);
        run_burst(1, 8'h6A, 4, 0, 2, NONE, 0, 6);
        set_mode(mkey(1, 1, 1));
        chk(mode_bad == 0, "R2 valid clears", int'(mode_bad), 0);
        run_burst(0, 8'h6B, 2, 1, 1, NONE, 0, 5);

        // R10: a write cuts a read burst (BL4, sequential, CL2)
        set_mode(mkey(2, 0, 2));
        @(negedge clk); rd_cmd = 1; cmd_col = 8'h12; #1;
        chk(col_addr == 8'h12 && col_valid, "R10 read beat0", int'(col_addr), 8'h12);
        @(negedge clk); rd_cmd = 0; #1;
        chk(col_addr == 8'h13 && col_valid && !col_write, "R10 read beat1", int'(col_addr), 8'h13);
        @(negedge clk); wr_cmd = 1; cmd_col = 8'h30; #1;
        chk(col_addr == 8'h30 && col_write, "R10 write beat0", int'(col_addr), 8'h30);
        chk(rd_valid == 1, "R10 read slot0 kept", int'(rd_valid), 1);
        @(negedge clk); wr_cmd = 0; #1;
        chk(col_addr == 8'h31 && col_write && wr_byte_en == 4'hF, "R10 write beat1",
            int'(col_addr), 8'h31);
        chk(rd_valid == 1, "R10 read slot1 kept", int'(rd_valid), 1);
        @(negedge clk); #1;
        chk(col_addr == 8'h32 && rd_valid == 0, "R10 no third read slot", int'(rd_valid), 0);
        @(negedge clk); #1;
        chk(col_addr == 8'h33 && col_write, "R10 write beat3", int'(col_addr), 8'h33);
        @(negedge clk); #1;
        chk(col_valid == 0, "R10 burst end", int'(col_valid), 0);

        // R12: collisions of strobes
        @(negedge clk); rd_cmd = 1; wr_cmd = 1; cmd_col = 8'h50; #1;
        chk(col_write == 1, "R12 write wins", int'(col_write), 1);
        @(negedge clk); rd_cmd = 0; wr_cmd = 0; #1;
        @(negedge clk); rd_cmd = 1; pre_cmd = 1; #1;
        chk(col_valid == 0, "R12 precharge wins", int'(col_valid), 0);
        @(negedge clk); rd_cmd = 0; pre_cmd = 0; #1;
        chk(col_valid == 0, "R12 no burst after", int'(col_valid), 0);
        repeat (3) begin
            @(negedge clk); #1;
            chk(rd_valid == 0, "R12 no read data", int'(rd_valid), 0);
        end

        finish_run();
    end

endmodule